// File: doc/BRIEF.md
# Memory-Error and Interrupt-Mask Register Bank

This block is a small bank of 32-bit registers reached over a plain single-cycle register bus. The bus carries a longword index, a byte-lane offset, write data and a combinational read return. The bank keeps four things: a free-form halt code word; a memory error status word with two parity control bits and a sticky parity-error flag; a read-only failing-address word; and one packed word that combines an eight-bit hardware interrupt request set, a video select bit, a video origin byte and an eight-bit interrupt mask.

A sideband error strobe from the memory controller raises the parity-error flag and records the low address bits of the failing access. Only the first failure is recorded until software clears the flag. Eight hardware request inputs set sticky request bits. The bank reports whether any unmasked request is pending and which one ranks highest, where a higher bit number wins. An acknowledge strobe retires that request. On the packed word, the byte lane of a write selects the operation: load the mask, load the origin, load the select bit, or clear requests.

Top module: `mem_err_irq_regs`

## Requirements
- R1: After reset every register index reads zero and the pending output is low.
- R2: Index 0 is a 32-bit read/write halt code; a write to it stores all 32 data bits regardless of lane.
- R3: Index 1 reads parity enable at bit 0, wrong-parity-write at bit 1, the parity-error flag at bit 6 and a fixed memory code value (parameter, default 0) at bit 8, with all other bits zero. A write loads only bits 0 and 1 from the data.
- R4: A write to index 1 with data bit 6 set clears the parity-error flag; with bit 6 clear the flag is unchanged. A parity strobe in the same cycle wins and leaves the flag set.
- R5: A parity strobe sets the flag and captures address bits 14:0 into index 2 only when the flag was clear. Index 2 reads those 15 bits zero-extended and ignores writes.
- R6: Index 3 reads requests in bits 31:24, select in bit 16, origin in bits 15:8 and mask in bits 7:0.
- R7: A write to index 3 takes its operand right-justified in data bits 7:0. Lane 0 loads the mask, lane 1 loads the origin, lane 2 loads data bit 0 into select, and lane 3 clears each request bit whose data bit is 1.
- R8: A high hardware request input sets its request bit on the next clock, and the bit stays set until cleared. A request input wins over a clear or acknowledge of the same bit in the same cycle.
- R9: Pending is high when any request bit is also set in the mask. The request identifier gives the highest-numbered such bit. An acknowledge while pending clears exactly that bit.
- R10: Indices 4 through 7 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busIdx | input | IDX_W (3) | Longword index |
| busLane | input | 2 | Byte offset within the longword |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, zero when not reading |
| hwReq | input | 8 | Hardware interrupt request inputs |
| parErr | input | 1 | Parity error strobe |
| parErrAddr | input | ADDR_W (32) | Address of the failing access |
| irqAck | input | 1 | Acknowledge of the reported request |
| irqPending | output | 1 | Some unmasked request is set |
| irqId | output | 3 | Highest-numbered unmasked request |

## Verification
The assertions assume a synchronous environment. Bus controls, request inputs, the parity strobe and acknowledge are all steady around the rising edge. Acknowledge is taken as meaningful only while pending is high. The bench meets these assumptions by changing inputs only on the falling edge, by holding each bus access for exactly one cycle, and by raising acknowledge only after it has seen pending. Collisions such as a request arriving with a clear or a parity strobe arriving with a flag clear are made deliberately in single cycles, so the rules for which action wins are exercised and stay within what the properties expect.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
  localparam int REQ_W = 8;
  localparam int ID_W  = $clog2(REQ_W);

  typedef enum logic [2:0] {
    RD_NONE,
    RD_HALT,
    RD_ERR,
    RD_FAD,
    RD_PACK
  } rdSel_e;

  typedef struct packed {
    logic             wrHalt;
    logic             wrErr;
    logic             wrMask;
    logic             wrOrigin;
    logic             wrSelect;
    logic             wrReqClr;
    logic [REQ_W-1:0] ackClr;
    rdSel_e           rdSel;
  } strobe_t;
endpackage

// File: rtl/mrf_ctrl.sv
module mrf_ctrl
  import mrf_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [IDX_W-1:0] busIdx,
  input  logic [1:0]       busLane,
  input  logic [REQ_W-1:0] reqMasked,
  input  logic             irqAck,
  output strobe_t          strobe,
  output logic             irqPending,
  output logic [ID_W-1:0]  irqId
);
  localparam int IDX_HALT = 0;
  localparam int IDX_ERR  = 1;
  localparam int IDX_FAD  = 2;
  localparam int IDX_PACK = 3;

  logic wrAcc, rdAcc;
  logic [ID_W-1:0] topId;

  assign wrAcc = busSel && busWr;
  assign rdAcc = busSel && !busWr;

  // highest-numbered unmasked request wins
  always_comb begin
    topId = '0;
    for (int i = 0; i < REQ_W; i++) begin
      if (reqMasked[i]) topId = ID_W'(i);
    end
  end

  assign irqPending = |reqMasked;
  assign irqId      = topId;

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = RD_NONE;
    strobe.wrHalt   = wrAcc && (busIdx == IDX_W'(IDX_HALT));
    strobe.wrErr    = wrAcc && (busIdx == IDX_W'(IDX_ERR));
    strobe.wrMask   = wrAcc && (busIdx == IDX_W'(IDX_PACK)) && (busLane == 2'd0);
    strobe.wrOrigin = wrAcc && (busIdx == IDX_W'(IDX_PACK)) && (busLane == 2'd1);
    strobe.wrSelect = wrAcc && (busIdx == IDX_W'(IDX_PACK)) && (busLane == 2'd2);
    strobe.wrReqClr = wrAcc && (busIdx == IDX_W'(IDX_PACK)) && (busLane == 2'd3);
    if (irqAck && irqPending) strobe.ackClr[topId] = 1'b1;
    if (rdAcc) begin
      if      (busIdx == IDX_W'(IDX_HALT)) strobe.rdSel = RD_HALT;
      else if (busIdx == IDX_W'(IDX_ERR))  strobe.rdSel = RD_ERR;
      else if (busIdx == IDX_W'(IDX_FAD))  strobe.rdSel = RD_FAD;
      else if (busIdx == IDX_W'(IDX_PACK)) strobe.rdSel = RD_PACK;
    end
  end

  // R9: acknowledge retires at most one request, and only an unmasked one
  p_ack_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.ackClr));
  p_ack_masked_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ackClr != '0) |-> ((strobe.ackClr & reqMasked) == strobe.ackClr));
  // R7: at most one packed-word operation per access
  p_lane_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrMask, strobe.wrOrigin, strobe.wrSelect, strobe.wrReqClr}));
endmodule

// File: rtl/mrf_dpath.sv
module mrf_dpath
  import mrf_pkg::*;
#(
  parameter int       ADDR_W    = 32,
  parameter int       FAD_W     = 15,
  parameter bit       MEM_CODE0 = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [31:0]       busWdata,
  input  logic [REQ_W-1:0]  hwReq,
  input  logic              parErr,
  input  logic [ADDR_W-1:0] parErrAddr,
  output logic [REQ_W-1:0]  reqMasked,
  output logic [31:0]       busRdata
);
  localparam int BIT_PEN  = 0;
  localparam int BIT_WWP  = 1;
  localparam int BIT_PERR = 6;

  logic [31:0]      haltReg;
  logic             parEnReg, wrongParReg, errFlag;
  logic [FAD_W-1:0] fadReg;
  logic [REQ_W-1:0] reqReg, maskReg;
  logic [7:0]       originReg;
  logic             selReg;
  logic [REQ_W-1:0] swClr;

  assign swClr     = strobe.wrReqClr ? busWdata[REQ_W-1:0] : '0;
  assign reqMasked = reqReg & maskReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltReg     <= '0;
      parEnReg    <= 1'b0;
      wrongParReg <= 1'b0;
      errFlag     <= 1'b0;
      fadReg      <= '0;
      reqReg      <= '0;
      maskReg     <= '0;
      originReg   <= '0;
      selReg      <= 1'b0;
    end else begin
      if (strobe.wrHalt) haltReg <= busWdata;
      if (strobe.wrErr) begin
        parEnReg    <= busWdata[BIT_PEN];
        wrongParReg <= busWdata[BIT_WWP];
      end
      if (parErr) begin
        errFlag <= 1'b1;
        if (!errFlag) fadReg <= parErrAddr[FAD_W-1:0];
      end else if (strobe.wrErr && busWdata[BIT_PERR]) begin
        errFlag <= 1'b0;
      end
      if (strobe.wrMask)   maskReg   <= busWdata[REQ_W-1:0];
      if (strobe.wrOrigin) originReg <= busWdata[7:0];
      if (strobe.wrSelect) selReg    <= busWdata[0];
      reqReg <= (reqReg & ~swClr & ~strobe.ackClr) | hwReq;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_HALT: busRdata = haltReg;
      RD_ERR:  busRdata = {23'd0, MEM_CODE0, 1'b0, errFlag, 4'd0, wrongParReg, parEnReg};
      RD_FAD:  busRdata = 32'(fadReg);
      RD_PACK: busRdata = {reqReg, 7'd0, selReg, originReg, maskReg};
      default: busRdata = '0;
    endcase
  end

  // R5: a strobe always leaves the flag set; a set flag freezes the address
  p_par_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    parErr |=> errFlag);
  p_fad_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> $stable(fadReg));
  // R4: a clearing write without a colliding strobe drops the flag
  p_err_w1c_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrErr && busWdata[BIT_PERR] && !parErr) |=> !errFlag);
  // R3: plain control bits move only on a status write
  p_ctl_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrErr |=> ($stable(parEnReg) && $stable(wrongParReg)));

  // R8: every asserted request input is latched on the next edge
  for (genvar g = 0; g < REQ_W; g++) begin : g_reqChk
    p_req_set_r8: assert property (@(posedge clk) disable iff (!rstN)
      hwReq[g] |=> reqReg[g]);
  end
endmodule

// File: rtl/mem_err_irq_regs.sv
module mem_err_irq_regs
  import mrf_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int ADDR_W    = 32,
  parameter int FAD_W     = 15,
  parameter bit MEM_CODE0 = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [IDX_W-1:0]  busIdx,
  input  logic [1:0]        busLane,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [REQ_W-1:0]  hwReq,
  input  logic              parErr,
  input  logic [ADDR_W-1:0] parErrAddr,
  input  logic              irqAck,
  output logic              irqPending,
  output logic [ID_W-1:0]   irqId
);
  strobe_t          strobe;
  logic [REQ_W-1:0] reqMasked;

  mrf_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWr      (busWr),
    .busIdx     (busIdx),
    .busLane    (busLane),
    .reqMasked  (reqMasked),
    .irqAck     (irqAck),
    .strobe     (strobe),
    .irqPending (irqPending),
    .irqId      (irqId)
  );

  mrf_dpath #(.ADDR_W(ADDR_W), .FAD_W(FAD_W), .MEM_CODE0(MEM_CODE0)) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busWdata   (busWdata),
    .hwReq      (hwReq),
    .parErr     (parErr),
    .parErrAddr (parErrAddr),
    .reqMasked  (reqMasked),
    .busRdata   (busRdata)
  );

  // R10: indices past the packed word return zero
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && (32'(busIdx) > 3)) |-> (busRdata == 32'd0));
  // R9: the reported identifier points at a pending unmasked request
  p_id_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqPending |-> reqMasked[irqId]);
endmodule

// File: tb/test_mem_err_irq_regs.sv
`timescale 1ns/1ps
module test_mem_err_irq_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [2:0]  busIdx = '0;
  logic [1:0]  busLane = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  hwReq = '0;
  logic        parErr = 1'b0;
  logic [31:0] parErrAddr = '0;
  logic        irqAck = 1'b0;
  logic        irqPending;
  logic [2:0]  irqId;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mem_err_irq_regs i_mem_err_irq_regs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busIdx(busIdx),
    .busLane(busLane), .busWdata(busWdata), .busRdata(busRdata), .hwReq(hwReq),
    .parErr(parErr), .parErrAddr(parErrAddr), .irqAck(irqAck),
    .irqPending(irqPending), .irqId(irqId)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int idx, input int lane, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busIdx = 3'(idx); busLane = 2'(lane); busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busIdx = 3'(idx);
    #1 v = busRdata;
    busSel = 1'b0;
  endtask

  task automatic pulseReq(input logic [7:0] r);
    @(negedge clk); hwReq = r;
    @(negedge clk); hwReq = '0;
  endtask

  task automatic pulsePar(input logic [31:0] a);
    @(negedge clk); parErr = 1'b1; parErrAddr = a;
    @(negedge clk); parErr = 1'b0;
  endtask

  function automatic logic [7:0] topBit(input logic [7:0] v);
    logic [7:0] r = 0;
    for (int i = 0; i < 8; i++) if (v[i]) r = 8'(i);
    return r;
  endfunction

  initial begin
    logic [31:0] v, expHalt, expFad;
    logic [7:0]  expReq, expMask, expOrg;
    logic        expSel;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int i = 0; i < 8; i++) begin rd(i, v); check("R1 reset read", v, 0); end
    check("R1 pending after reset", 32'(irqPending), 0);

    // R2 halt code, lanes irrelevant
    for (int k = 0; k < 8; k++) begin
      expHalt = 32'h9E37_79B9 * (k + 1);
      wr(0, k % 4, expHalt);
      rd(0, v); check("R2 halt code", v, expHalt);
    end

    // R3 error status write sweep: only bits 0,1 stored
    for (int k = 0; k < 16; k++) begin
      v = {k[3] ? 24'hFFFFFF : 24'h0, 2'b10, k[2] ? 4'hF : 4'h0, k[1:0]} & ~32'h40;
      wr(1, 0, v | (k[2] ? 32'h100 : 0));
      rd(1, v); check("R3 status bits", v, 32'(k[1:0]));
    end
    wr(1, 0, 32'h0);

    // R5 parity capture, R4 clearing
    pulsePar(32'hABC1_2345);
    expFad = 32'hABC1_2345 & 32'h7FFF;
    rd(1, v); check("R5 flag set", v, 32'h40);
    rd(2, v); check("R5 address captured", v, expFad);
    pulsePar(32'h0000_7FFF);
    rd(2, v); check("R5 first address kept", v, expFad);
    wr(2, 0, 32'hFFFF_FFFF);
    rd(2, v); check("R5 write ignored", v, expFad);
    wr(1, 0, 32'h0000_0003);
    rd(1, v); check("R4 zero in bit 6 keeps flag", v, 32'h43);
    wr(1, 0, 32'h0000_0040);
    rd(1, v); check("R4 one in bit 6 clears flag", v, 32'h0);
    // collision: clear and new strobe in one cycle, strobe wins
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busIdx = 3'd1; busLane = 2'd0; busWdata = 32'h41;
    parErr = 1'b1; parErrAddr = 32'h0001_ABCD;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; parErr = 1'b0;
    rd(1, v); check("R4 strobe beats clear", v, 32'h41);
    rd(2, v); check("R5 recapture after clear", v, 32'h0001_ABCD & 32'h7FFF);
    wr(1, 0, 32'h40);

    // R6/R7 packed word lane decode
    expReq = 0; expMask = 0; expOrg = 0; expSel = 0;
    for (int k = 0; k < 12; k++) begin
      v = 32'h5A5A_5A00 | 32'((k * 37 + 11) & 8'hFF);
      wr(3, k % 3, v);
      case (k % 3)
        0: expMask = v[7:0];
        1: expOrg  = v[7:0];
        default: expSel = v[0];
      endcase
      rd(3, v);
      check("R7 lane write / R6 packing", v, {expReq, 7'd0, expSel, expOrg, expMask});
    end

    // R8 sticky requests, R7 lane-3 clear
    for (int i = 0; i < 8; i++) begin
      pulseReq(8'(1 << i)); expReq |= 8'(1 << i);
      rd(3, v); check("R8 request sticky", {24'd0, v[31:24]}, 32'(expReq));
    end
    wr(3, 3, 32'hFFFF_FF5A); expReq &= ~8'h5A;
    rd(3, v); check("R7 request clear", {24'd0, v[31:24]}, 32'(expReq));
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busIdx = 3'd3; busLane = 2'd3; busWdata = 32'h04;
    hwReq = 8'h04;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; hwReq = 0; expReq |= 8'h04;
    rd(3, v); check("R8 request beats clear", {24'd0, v[31:24]}, 32'(expReq));

    // R9 exhaustive mask sweep
    for (int m = 0; m < 256; m++) begin
      wr(3, 0, 32'(m)); expMask = 8'(m);
      #1;
      check("R9 pending", 32'(irqPending), 32'(|(expReq & expMask)));
      if (|(expReq & expMask)) check("R9 id", 32'(irqId), 32'(topBit(expReq & expMask)));
    end
    // R9 acknowledge drain
    pulseReq(8'hFF); expReq = 8'hFF;
    wr(3, 0, 32'hDB); expMask = 8'hDB;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      if (irqPending) begin
        check("R9 ack id", 32'(irqId), 32'(topBit(expReq & expMask)));
        irqAck = 1'b1;
        @(negedge clk);
        irqAck = 1'b0;
        expReq &= ~8'(1 << topBit(expReq & expMask));
      end
    end
    rd(3, v); check("R9 ack leaves masked-off bits", {24'd0, v[31:24]}, 32'(expReq));
    check("R9 drained", 32'(irqPending), 0);

    // R10 unused indices
    for (int i = 4; i < 8; i++) begin
      wr(i, i % 4, 32'hFFFF_FFFF);
      rd(i, v); check("R10 unused reads zero", v, 0);
    end
    rd(0, v); check("R10 halt untouched", v, expHalt);
    rd(3, v); check("R10 packed untouched", v, {expReq, 7'd0, expSel, expOrg, expMask});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog got=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule